// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block serves one gather read for a group of lanes from an on-chip scratchpad. The scratchpad is split into word-wide banks. Each lane gives a word address and an active bit. The arbiter finds the bank of every active address and works out which lanes collide. In each pass it reads at most one distinct address per bank. Every pending lane that asked for that same address is served from that single read. Lanes that ask for different addresses in one bank are therefore the only ones that cost extra passes. Lanes that share an address are folded into one broadcast, or into one multicast per address group.

A request is taken when `req_valid` is high and the block is idle. From then on the block runs one pass per cycle. Results build up in a per-lane data vector with a valid mask. When the last pending lane is served, `done` pulses for one cycle. A status count then gives the number of passes used, which is the largest number of distinct addresses that fell into any one bank. A single-word fill port loads the scratchpad.

Top module: `spb_conflict_arb`

## Requirements
- R1: Word address `a` is stored in bank `a mod BANKS` at row `a / BANKS`. A fill cycle (`fill_en` high) writes `fill_data` to that word, and a later read of `a` returns it.
- R2: When every active lane falls in a different bank, the request takes one pass. `done` rises at the first rising edge after the accepting edge and stays high for exactly one cycle.
- R3: When N lanes ask for N different addresses in the same bank, the request takes N passes. `done` rises at the Nth edge after acceptance.
- R4: Lanes that all ask for one identical address are served together in a single pass.
- R5: Several groups of lanes, each group sharing one address, cost one pass per distinct address in the busiest bank, not one pass per lane.
- R6: `pass_cnt` equals the largest count of distinct active addresses in any single bank. It is valid from `done` until the next request is accepted.
- R7: Within a bank, each pass serves the address of the lowest-numbered lane still pending, together with every pending lane that shares that address. `rsp_valid` shows the lanes served so far after each pass.
- R8: Inactive lanes add no conflicts and never get a valid bit.
- R9: A request with no active lane completes at the first edge after acceptance, with `rsp_valid` all zero and `pass_cnt` zero.
- R10: At `done`, `rsp_valid` equals the accepted active mask. Each valid lane's slice of `rsp_data` holds the word at its address, and invalid lanes read zero. All three results hold until the next acceptance.
- R11: A `req_valid` pulse while `busy` is high is ignored and does not change the request in flight.
- R12: After reset, `busy`, `done`, `rsp_valid` and `pass_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| fill_en | input | 1 | Write one scratchpad word this cycle |
| fill_addr | input | ADDR_W | Word address of the fill |
| fill_data | input | DATA_W | Word to write |
| req_valid | input | 1 | Offer a request; taken only while idle |
| req_active | input | LANES | Per-lane active bits |
| req_addr | input | LANES*ADDR_W | Per-lane word addresses; lane l uses bits [l*ADDR_W +: ADDR_W] |
| busy | output | 1 | A request is being served |
| done | output | 1 | One-cycle pulse when the last lane is served |
| rsp_valid | output | LANES | Lanes served so far |
| rsp_data | output | LANES*DATA_W | Per-lane read data; lane l at [l*DATA_W +: DATA_W] |
| pass_cnt | output | CNT_W | Number of passes used by the request |

## Verification
The bench builds the block with its defaults: 32 lanes, 32 banks of 32 rows, and 32-bit words, which gives a 1024-word scratchpad. That size fits a full column walk with a 32-word row stride, which puts every lane in one bank and needs 32 passes. It also fits the 33-word padded stride, which spreads the lanes over all banks in one pass. The vector table also covers stride 2 and stride 16 conflicts, a full broadcast, and multicast groups with and without bank collisions. It also covers a sparse active mask whose addresses alias modulo the scratchpad size. Directed cases observe the pass-by-pass valid mask to confirm lowest-lane priority, and inject a request while busy.

// File: rtl/spb_pkg.sv
package spb_pkg;
   typedef enum logic {
      SPB_IDLE = 1'b0,
      SPB_RUN  = 1'b1
   } spb_state_e;

   function automatic int unsigned spb_cnt_width(input int unsigned n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/spb_bank_store.sv
module spb_bank_store #(
   parameter int unsigned BANKS  = 32,
   parameter int unsigned ROWS   = 32,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned BANK_W = $clog2(BANKS),
   localparam int unsigned ROW_W  = $clog2(ROWS),
   localparam int unsigned ADDR_W = BANK_W + ROW_W
) (
   input  logic                    clk,
   input  logic                    fill_en,
   input  logic [ADDR_W-1:0]       fill_addr,
   input  logic [DATA_W-1:0]       fill_data,
   input  logic [BANKS*ROW_W-1:0]  rd_row,
   output logic [BANKS*DATA_W-1:0] rd_data
);
   logic [BANK_W-1:0] fill_bank;
   logic [ROW_W-1:0]  fill_row;

   assign fill_bank = fill_addr[BANK_W-1:0];
   assign fill_row  = fill_addr[ADDR_W-1:BANK_W];

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic [DATA_W-1:0] mem [ROWS];

      always_ff @(posedge clk) begin
         if (fill_en && (fill_bank == BANK_W'(b))) begin
            mem[fill_row] <= fill_data;
         end
      end

      assign rd_data[b*DATA_W +: DATA_W] = mem[rd_row[b*ROW_W +: ROW_W]];
   end
endmodule

// File: rtl/spb_bank_pick.sv
module spb_bank_pick #(
   parameter int unsigned LANES   = 32,
   parameter int unsigned BANKS   = 32,
   parameter int unsigned ADDR_W  = 10,
   parameter int unsigned BANK_ID = 0,
   localparam int unsigned BANK_W = $clog2(BANKS),
   localparam int unsigned ROW_W  = ADDR_W - BANK_W
) (
   input  logic [LANES-1:0]        pending,
   input  logic [LANES*ADDR_W-1:0] lane_addr,
   output logic                    hit,
   output logic [ROW_W-1:0]        win_row,
   output logic [LANES-1:0]        served
);
   logic [LANES-1:0]  match;
   logic [ADDR_W-1:0] win_addr;

   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         match[l] = pending[l] &&
                    (lane_addr[l*ADDR_W +: BANK_W] == BANK_W'(BANK_ID));
      end
      win_addr = '0;
      for (int l = LANES - 1; l >= 0; l--) begin
         if (match[l]) begin
            win_addr = lane_addr[l*ADDR_W +: ADDR_W];
         end
      end
      for (int l = 0; l < LANES; l++) begin
         served[l] = match[l] && (lane_addr[l*ADDR_W +: ADDR_W] == win_addr);
      end
   end

   assign hit     = |match;
   assign win_row = win_addr[ADDR_W-1:BANK_W];
endmodule

// File: rtl/spb_lane_route.sv
module spb_lane_route #(
   parameter int unsigned LANES  = 32,
   parameter int unsigned BANKS  = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 10,
   localparam int unsigned BANK_W = $clog2(BANKS)
) (
   input  logic [LANES*ADDR_W-1:0] lane_addr,
   input  logic [BANKS*DATA_W-1:0] rd_data,
   output logic [LANES*DATA_W-1:0] lane_data
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [BANK_W-1:0] bsel;
      assign bsel = lane_addr[l*ADDR_W +: BANK_W];
      assign lane_data[l*DATA_W +: DATA_W] = rd_data[bsel*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/spb_conflict_arb.sv
module spb_conflict_arb #(
   parameter int unsigned LANES  = 32,
   parameter int unsigned BANKS  = 32,
   parameter int unsigned ROWS   = 32,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned BANK_W = $clog2(BANKS),
   localparam int unsigned ROW_W  = $clog2(ROWS),
   localparam int unsigned ADDR_W = BANK_W + ROW_W,
   localparam int unsigned CNT_W  = spb_pkg::spb_cnt_width(LANES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fill_en,
   input  logic [ADDR_W-1:0]       fill_addr,
   input  logic [DATA_W-1:0]       fill_data,
   input  logic                    req_valid,
   input  logic [LANES-1:0]        req_active,
   input  logic [LANES*ADDR_W-1:0] req_addr,
   output logic                    busy,
   output logic                    done,
   output logic [LANES-1:0]        rsp_valid,
   output logic [LANES*DATA_W-1:0] rsp_data,
   output logic [CNT_W-1:0]        pass_cnt
);
   import spb_pkg::*;

   if (BANKS < 2 || (1 << BANK_W) != BANKS) begin : g_bad_banks
      $error("BANKS must be a power of two of at least 2");
   end
   if (ROWS < 2 || (1 << ROW_W) != ROWS) begin : g_bad_rows
      $error("ROWS must be a power of two of at least 2");
   end
   if (LANES < 1 || DATA_W < 1) begin : g_bad_lanes
      $error("LANES and DATA_W must be positive");
   end

   spb_state_e              state;
   logic [LANES-1:0]        act_q;
   logic [LANES-1:0]        pending;
   logic [LANES*ADDR_W-1:0] addr_q;

   logic [BANKS-1:0]        bank_hit;
   logic [BANKS*ROW_W-1:0]  bank_row;
   logic [LANES-1:0]        bank_served [BANKS];
   logic [LANES-1:0]        served;
   logic [BANKS*DATA_W-1:0] rd_data;
   logic [LANES*DATA_W-1:0] lane_data;
   logic [LANES-1:0]        left;

   assign busy = (state == SPB_RUN);

   for (genvar b = 0; b < BANKS; b++) begin : g_pick
      spb_bank_pick #(
         .LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W), .BANK_ID(b)
      ) u_pick (
         .pending  (pending),
         .lane_addr(addr_q),
         .hit      (bank_hit[b]),
         .win_row  (bank_row[b*ROW_W +: ROW_W]),
         .served   (bank_served[b])
      );
   end

   always_comb begin
      served = '0;
      for (int b = 0; b < BANKS; b++) begin
         served = served | bank_served[b];
      end
   end

   spb_bank_store #(
      .BANKS(BANKS), .ROWS(ROWS), .DATA_W(DATA_W)
   ) u_store (
      .clk      (clk),
      .fill_en  (fill_en),
      .fill_addr(fill_addr),
      .fill_data(fill_data),
      .rd_row   (bank_row),
      .rd_data  (rd_data)
   );

   spb_lane_route #(
      .LANES(LANES), .BANKS(BANKS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_route (
      .lane_addr(addr_q),
      .rd_data  (rd_data),
      .lane_data(lane_data)
   );

   assign left = pending & ~served;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SPB_IDLE;
         act_q     <= '0;
         pending   <= '0;
         addr_q    <= '0;
         rsp_valid <= '0;
         rsp_data  <= '0;
         pass_cnt  <= '0;
         done      <= 1'b0;
      end else if (state == SPB_IDLE) begin
         done <= 1'b0;
         if (req_valid) begin
            state     <= SPB_RUN;
            act_q     <= req_active;
            pending   <= req_active;
            addr_q    <= req_addr;
            rsp_valid <= '0;
            rsp_data  <= '0;
            pass_cnt  <= '0;
         end
      end else begin
         pending   <= left;
         rsp_valid <= rsp_valid | served;
         for (int l = 0; l < LANES; l++) begin
            if (served[l]) begin
               rsp_data[l*DATA_W +: DATA_W] <= lane_data[l*DATA_W +: DATA_W];
            end
         end
         if (|bank_hit) begin
            pass_cnt <= pass_cnt + CNT_W'(1);
         end
         if (left == '0) begin
            state <= SPB_IDLE;
            done  <= 1'b1;
         end
      end
   end

   // R8
   served_only_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ((served & ~pending) == '0));

   // R8
   valid_in_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid & ~act_q) == '0);

   // R10
   done_all_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rsp_valid == act_q));

   // R3
   progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && pending != '0) |=> ($countones(pending) < $past($countones(pending))));

   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   pass_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pass_cnt <= CNT_W'(LANES));

   // R11
   ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid) |=> $stable(act_q));
endmodule

// File: tb/tb_spb_conflict_arb.sv
module tb_spb_conflict_arb;
   localparam int LANES = 32;
   localparam int AW    = 10;
   localparam int DW    = 32;
   localparam int WORDS = 1024;
   localparam int CW    = 6;

   typedef struct packed {
      logic        grouped;
      logic [9:0]  base;
      logic [10:0] stride;
      logic [5:0]  grp;
      logic [31:0] act;
      logic [5:0]  passes;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 10'd0,   11'd1,  6'd1,  32'hFFFF_FFFF, 6'd1},  // R2 unit stride
      '{1'b0, 10'd0,   11'd32, 6'd1,  32'hFFFF_FFFF, 6'd32}, // R3 column walk
      '{1'b0, 10'd5,   11'd33, 6'd1,  32'hFFFF_FFFF, 6'd1},  // R2 padded stride
      '{1'b0, 10'd0,   11'd2,  6'd1,  32'hFFFF_FFFF, 6'd2},  // R3 stride 2
      '{1'b0, 10'd0,   11'd16, 6'd1,  32'hFFFF_FFFF, 6'd16}, // R3 stride 16
      '{1'b1, 10'd77,  11'd0,  6'd32, 32'hFFFF_FFFF, 6'd1},  // R4 broadcast
      '{1'b1, 10'd3,   11'd32, 6'd8,  32'hFFFF_FFFF, 6'd4},  // R5 multicast same bank
      '{1'b1, 10'd10,  11'd1,  6'd4,  32'hFFFF_FFFF, 6'd1},  // R5 multicast spread
      '{1'b0, 10'd0,   11'd32, 6'd1,  32'h0000_000F, 6'd4},  // R8 sparse active
      '{1'b0, 10'd1,   11'd64, 6'd1,  32'hAAAA_AAAA, 6'd8},  // R5 aliasing groups
      '{1'b0, 10'd0,   11'd1,  6'd1,  32'h0000_0000, 6'd0}   // R9 empty
   };

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                fill_en = 1'b0;
   logic [AW-1:0]       fill_addr = '0;
   logic [DW-1:0]       fill_data = '0;
   logic                req_valid = 1'b0;
   logic [LANES-1:0]    req_active = '0;
   logic [LANES*AW-1:0] req_addr = '0;
   logic                busy, done;
   logic [LANES-1:0]    rsp_valid;
   logic [LANES*DW-1:0] rsp_data;
   logic [CW-1:0]       pass_cnt;

   int checks = 0;
   int fails  = 0;
   logic [DW-1:0] model [WORDS];
   logic [AW-1:0] cur_addr [LANES];
   logic [LANES-1:0] cur_act;
   int done_cyc;
   logic [LANES-1:0] valid_at [4];

   always #10 clk = ~clk;

   spb_conflict_arb dut (
      .clk(clk), .rst_n(rst_n),
      .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data),
      .req_valid(req_valid), .req_active(req_active), .req_addr(req_addr),
      .busy(busy), .done(done), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .pass_cnt(pass_cnt)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic fill_word(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      fill_en   = 1'b1;
      fill_addr = AW'(a);
      fill_data = d;
      model[a]  = d;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic issue(input int inj_cyc);
      @(negedge clk);
      req_valid  = 1'b1;
      req_active = cur_act;
      for (int l = 0; l < LANES; l++) req_addr[l*AW +: AW] = cur_addr[l];
      @(negedge clk);
      req_valid = 1'b0;
      done_cyc  = 0;
      do begin
         @(negedge clk);
         done_cyc++;
         if (done_cyc <= 3) valid_at[done_cyc] = rsp_valid;
         req_valid = (done_cyc == inj_cyc);
         if (req_valid) begin
            req_active = '1;
            for (int l = 0; l < LANES; l++) req_addr[l*AW +: AW] = AW'(l + 200);
         end
      end while (!done && done_cyc < 200);
      req_valid = 1'b0;
   endtask

   task automatic check_data(input string tag);
      int bad = 0;
      logic [DW-1:0] a_v = '0, e_v = '0;
      for (int l = 0; l < LANES; l++) begin
         logic [DW-1:0] e = cur_act[l] ? model[cur_addr[l]] : '0;
         if (rsp_data[l*DW +: DW] !== e) begin
            if (bad == 0) begin
               a_v = rsp_data[l*DW +: DW];
               e_v = e;
            end
            bad++;
         end
      end
      chk(bad == 0, tag, a_v, e_v);
   endtask

   task automatic check_result(input int exp_passes, input string tag);
      int exp_cyc = (exp_passes < 1) ? 1 : exp_passes;
      chk(done === 1'b1 && done_cyc == exp_cyc, {tag, " done cycle R2 R3"},
          done_cyc, exp_cyc);
      chk(pass_cnt == CW'(exp_passes), {tag, " pass count R6"}, pass_cnt, exp_passes);
      chk(rsp_valid == cur_act, {tag, " valid mask R8 R10"}, rsp_valid, cur_act);
      check_data({tag, " data R10"});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk(busy == 1'b0 && done == 1'b0, "R12 busy/done after reset", {busy, done}, 0);
      chk(rsp_valid == '0 && pass_cnt == '0, "R12 valid/count after reset",
          {rsp_valid, pass_cnt}, 0);
      rst_n = 1'b1;

      for (int a = 0; a < WORDS; a++) fill_word(a, 32'hC0DE_0000 + DW'(a));

      foreach (VECS[i]) begin
         vec_t v = VECS[i];
         cur_act = v.act;
         for (int l = 0; l < LANES; l++) begin
            int off = v.grouped ? (l / int'(v.grp)) * int'(v.stride) : l * int'(v.stride);
            cur_addr[l] = AW'((int'(v.base) + off) % WORDS);
         end
         issue(0);
         check_result(int'(v.passes), $sformatf("vector %0d", i));
      end

      // R1: fill overwrite and bank mapping (517 and 5 share bank 5, 6 is bank 6)
      fill_word(517, 32'h1234_5678);
      cur_act = 32'h7;
      for (int l = 0; l < LANES; l++) cur_addr[l] = '0;
      cur_addr[0] = 10'd517; cur_addr[1] = 10'd5; cur_addr[2] = 10'd6;
      issue(0);
      check_result(2, "R1 mapping");

      // R7: lane0/lane2 at 64, lane1 at 0, lane3 at 32, all bank 0
      cur_act = 32'hF;
      cur_addr[0] = 10'd64; cur_addr[1] = 10'd0; cur_addr[2] = 10'd64; cur_addr[3] = 10'd32;
      issue(0);
      chk(valid_at[1] == 32'h5, "R7 first pass lanes", valid_at[1], 32'h5);
      chk(valid_at[2] == 32'h7, "R7 second pass lanes", valid_at[2], 32'h7);
      check_result(3, "R7 order");

      // R11: column walk with a request injected while busy
      cur_act = '1;
      for (int l = 0; l < LANES; l++) cur_addr[l] = AW'(l * 32);
      issue(3);
      check_result(32, "R11 ignore while busy");
      repeat (3) @(negedge clk);
      chk(rsp_valid == cur_act && pass_cnt == CW'(32), "R10 results held",
          {rsp_valid, pass_cnt}, {cur_act, 6'd32});
      check_data("R10 data held");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule